// File: doc/BRIEF.md
# Single-Entry Eviction Writeback Buffer

This block holds one line that a level-one cache is evicting. When the cache replaces a line, the block copies the line's address, data and dirty bit into a local buffer. It tells the cache it may drop the line at once, and it queues a victim notice toward the home node. Lines held in a clean state produce a clean notice. Lines that own the data produce a dirty notice that carries the data. The buffer then waits for the home node to accept or refuse the writeback. In that window it answers any coherence probe for the evicted line out of its own copy.

A probe that invalidates the line while the writeback is still pending cancels the writeback. From then on, an acceptance from the home node produces only a stale notice, because the data has already gone elsewhere. A downgrade probe that arrives before any cancel marks the buffered copy as shared, and that mark travels with the data when the writeback is accepted. Every outgoing message, on either channel, waits a fixed number of cycles before it appears, which stands in for the trip to the next cache level. While the buffer is occupied, a lookup output tells the cache to hold back any load, store or replacement that targets the buffered line.

Top module: `victim_wb_buf`

## Requirements
- R1: After synchronous reset, `busy`, `req_valid` and `rsp_valid` are 0 and `repl_ready` is 1.
- R2: Replacing a line whose state code is S (0) or E (1) emits a request with kind 0 (clean victim), data 0 and dirty 0. Its shared flag is 1 only for S.
- R3: Replacing a line whose state code is O (2) or M (3) emits a request with kind 1 (dirty victim), the line's data and its dirty bit. Its shared flag is 1 only for O.
- R4: After a replacement is accepted, `busy` is 1 and `repl_ready` is 0. `lk_hold` is 1 when `lk_addr` equals the buffered address and 0 for any other address.
- R5: Before any cancel, a response of kind 0 (ack) emits response kind 0 (writeback data) carrying the buffered data, the dirty bit and the probe-shared flag, and then frees the buffer.
- R6: A response of kind 1 (nack) frees the buffer and emits no message, whether or not the writeback was cancelled.
- R7: Before any cancel, a probe of kind 2 (downgrade) emits response kind 2 (probe data) with the buffered data and dirty bit. It sets the probe-shared flag and leaves the buffer occupied.
- R8: Before any cancel, a probe of kind 1 (invalidate with data) emits response kind 2, and a probe of kind 0 (invalidate) emits response kind 3 (probe, no data). Either one cancels the writeback.
- R9: After a cancel, an ack emits response kind 1 (stale, data 0, dirty 0, shared 0) and frees the buffer. Invalidate probes of either kind emit response kind 3 and leave the buffer cancelled.
- R10: After a cancel, a downgrade probe emits response kind 4 (probe miss, no data).
- R11: Each outgoing message first appears exactly ISSUE_LAT cycles after the clock edge that produced it. It stays valid, with unchanged contents, until it is taken.
- R12: When a probe and a response are offered in the same cycle, only the probe is taken. The response stays pending and is handled after the probe.
- R13: While the buffer is empty, probes and responses are not taken, and no response message appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_valid | input | 1 | Replacement offered |
| repl_ready | output | 1 | Replacement can be taken |
| repl_state | input | 2 | Line state: 0 S, 1 E, 2 O, 3 M |
| repl_addr | input | ADDR_W | Line address of the victim |
| repl_data | input | DATA_W | Victim data |
| repl_dirty | input | 1 | Victim dirty bit |
| lk_addr | input | ADDR_W | Address of a pending cache access |
| lk_hold | output | 1 | The access targets the buffered line and must retry |
| busy | output | 1 | Buffer occupied |
| resp_valid | input | 1 | Home-node response offered |
| resp_ready | output | 1 | Response taken this cycle |
| resp_kind | input | 1 | 0 ack, 1 nack |
| prb_valid | input | 1 | Probe for the buffered line offered |
| prb_ready | output | 1 | Probe taken this cycle |
| prb_kind | input | 2 | 0 invalidate, 1 invalidate with data, 2 downgrade |
| req_valid | output | 1 | Victim request valid |
| req_ready | input | 1 | Victim request taken |
| req_kind | output | 1 | 0 clean victim, 1 dirty victim |
| req_addr | output | ADDR_W | Victim address |
| req_data | output | DATA_W | Victim data (dirty kind only) |
| req_dirty | output | 1 | Dirty bit (dirty kind only) |
| req_shared | output | 1 | Line was held shared |
| rsp_valid | output | 1 | Response message valid |
| rsp_ready | input | 1 | Response message taken |
| rsp_kind | output | 3 | 0 wb data, 1 stale, 2 probe data, 3 probe no data, 4 probe miss |
| rsp_addr | output | ADDR_W | Buffered address |
| rsp_data | output | DATA_W | Data field |
| rsp_dirty | output | 1 | Dirty field |
| rsp_shared | output | 1 | Probe-shared flag (wb data only) |

## Verification
The bench builds the block with ADDR_W and DATA_W set to 8 and ISSUE_LAT set to 3. With a latency that short, every message's arrival cycle can be counted exactly, and each scenario stays within a few dozen cycles. That budget lets the bench sweep all four victim states against eight probe and response sequences: plain ack and nack, a downgrade before an ack, each invalidate kind before an ack or a nack, a miss after a cancel, and repeated probes. The expected kind, data, dirty and shared fields of every message come from a small model of the flags held in the bench. Separate runs cover a probe and a response offered together, output backpressure, and stimulus sent while the buffer is empty.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

    typedef enum logic [1:0] {
        LS_SHARED = 2'd0,
        LS_EXCL   = 2'd1,
        LS_OWNED  = 2'd2,
        LS_MOD    = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        PK_INV      = 2'd0,
        PK_INV_DATA = 2'd1,
        PK_DOWN     = 2'd2
    } prb_kind_e;

    typedef enum logic {
        HR_ACK  = 1'b0,
        HR_NACK = 1'b1
    } home_resp_e;

    typedef enum logic {
        VK_CLEAN = 1'b0,
        VK_DIRTY = 1'b1
    } vic_kind_e;

    typedef enum logic [2:0] {
        RK_WB_DATA  = 3'd0,
        RK_STALE    = 3'd1,
        RK_PRB_DATA = 3'd2,
        RK_PRB_NONE = 3'd3,
        RK_PRB_MISS = 3'd4
    } rsp_kind_e;

    typedef enum logic [1:0] {
        WB_IDLE   = 2'd0,
        WB_CLEAN  = 2'd1,
        WB_DIRTY  = 2'd2,
        WB_CANCEL = 2'd3
    } wb_state_e;

    function automatic logic owns_data(line_st_e s);
        return (s == LS_OWNED) || (s == LS_MOD);
    endfunction

    function automatic logic held_shared(line_st_e s);
        return (s == LS_SHARED) || (s == LS_OWNED);
    endfunction

endpackage

// File: rtl/vwb_slot.sv
module vwb_slot #(
    parameter int W   = 8,
    parameter int LAT = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         free,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int CW = (LAT < 1) ? 1 : $clog2(LAT + 1);
    localparam logic [CW-1:0] LAT_C = CW'(LAT);

    logic          full_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            full_q <= 1'b1;
            cnt_q  <= LAT_C;
            data_q <= load_data;
        end else if (full_q) begin
            if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            else if (out_ready)
                full_q <= 1'b0;
        end
    end

    assign free      = !full_q;
    assign out_valid = full_q && (cnt_q == '0);
    assign out_data  = data_q;

    AST_SLOT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        load |-> free) else $error("slot overwritten"); // R11

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("slot dropped"); // R11

    AST_SLOT_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (LAT > 0 && load) |=> !out_valid) else $error("slot early"); // R11

endmodule

// File: rtl/vwb_ctrl.sv
module vwb_ctrl
    import vwb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              repl_valid,
    input  logic [1:0]        repl_state,
    input  logic [ADDR_W-1:0] repl_addr,
    input  logic [DATA_W-1:0] repl_data,
    input  logic              repl_dirty,
    output logic              repl_ready,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hold,
    output logic              busy,
    input  logic              resp_valid,
    input  logic              resp_kind,
    output logic              resp_ready,
    input  logic              prb_valid,
    input  logic [1:0]        prb_kind,
    output logic              prb_ready,
    input  logic              req_free,
    input  logic              rsp_free,
    output logic              req_load,
    output logic              rq_kind,
    output logic [ADDR_W-1:0] rq_addr,
    output logic [DATA_W-1:0] rq_data,
    output logic              rq_dirty,
    output logic              rq_shared,
    output logic              rsp_load,
    output logic [2:0]        rs_kind,
    output logic [ADDR_W-1:0] rs_addr,
    output logic [DATA_W-1:0] rs_data,
    output logic              rs_dirty,
    output logic              rs_shared
);
    wb_state_e         state_q, state_n;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              dirty_q;
    logic              psh_q, psh_n;
    rsp_kind_e         rk;
    line_st_e          ls_in;
    prb_kind_e         pk;

    logic active, repl_fire, prb_fire, resp_fire;

    assign ls_in = line_st_e'(repl_state);
    assign pk    = prb_kind_e'(prb_kind);

    assign active     = (state_q != WB_IDLE);
    assign busy       = active;
    assign repl_ready = !active && req_free;
    assign repl_fire  = repl_valid && repl_ready;
    assign prb_ready  = active && rsp_free;
    assign prb_fire   = prb_valid && prb_ready;
    assign resp_ready = active && rsp_free && !prb_valid;
    assign resp_fire  = resp_valid && resp_ready;
    assign lk_hold    = active && (lk_addr == addr_q);

    // victim notice built straight from the replacement inputs
    always_comb begin
        req_load  = repl_fire;
        rq_addr   = repl_addr;
        rq_shared = held_shared(ls_in);
        if (owns_data(ls_in)) begin
            rq_kind  = VK_DIRTY;
            rq_data  = repl_data;
            rq_dirty = repl_dirty;
        end else begin
            rq_kind  = VK_CLEAN;
            rq_data  = '0;
            rq_dirty = 1'b0;
        end
    end

    always_comb begin
        state_n   = state_q;
        psh_n     = psh_q;
        rsp_load  = 1'b0;
        rk        = RK_PRB_NONE;
        rs_data   = '0;
        rs_dirty  = 1'b0;
        rs_shared = 1'b0;
        if (prb_fire) begin
            rsp_load = 1'b1;
            if (state_q == WB_CANCEL) begin
                rk = (pk == PK_DOWN) ? RK_PRB_MISS : RK_PRB_NONE;
            end else begin
                case (pk)
                    PK_DOWN: begin
                        rk       = RK_PRB_DATA;
                        rs_data  = data_q;
                        rs_dirty = dirty_q;
                        psh_n    = 1'b1;
                    end
                    PK_INV_DATA: begin
                        rk       = RK_PRB_DATA;
                        rs_data  = data_q;
                        rs_dirty = dirty_q;
                        state_n  = WB_CANCEL;
                    end
                    default: begin
                        rk      = RK_PRB_NONE;
                        state_n = WB_CANCEL;
                    end
                endcase
            end
        end else if (resp_fire) begin
            state_n = WB_IDLE;
            if (resp_kind == HR_ACK) begin
                rsp_load = 1'b1;
                if (state_q == WB_CANCEL) begin
                    rk = RK_STALE;
                end else begin
                    rk        = RK_WB_DATA;
                    rs_data   = data_q;
                    rs_dirty  = dirty_q;
                    rs_shared = psh_q;
                end
            end
        end
        if (repl_fire)
            state_n = owns_data(ls_in) ? WB_DIRTY : WB_CLEAN;
    end

    assign rs_kind = rk;
    assign rs_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WB_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            dirty_q <= 1'b0;
            psh_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (repl_fire) begin
                addr_q  <= repl_addr;
                data_q  <= repl_data;
                dirty_q <= repl_dirty;
                psh_q   <= 1'b0;
            end else begin
                psh_q <= psh_n;
            end
        end
    end

    AST_RESP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        resp_fire |=> !busy) else $error("buffer not freed"); // R6

    AST_DOWN_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (prb_fire && pk == PK_DOWN && state_q != WB_CANCEL)
        |=> (state_q == $past(state_q)) && psh_q) else $error("downgrade lost"); // R7

    AST_INV_CANCELS: assert property (@(posedge clk) disable iff (rst)
        (prb_fire && pk != PK_DOWN) |=> (state_q == WB_CANCEL)) else $error("no cancel"); // R8

    AST_PROBE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (prb_fire && resp_valid) |=> busy) else $error("response beat probe"); // R12

    AST_IDLE_REFUSES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rsp_load) else $error("idle message"); // R13

endmodule

// File: rtl/victim_wb_buf.sv
module victim_wb_buf #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int ISSUE_LAT = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              repl_valid,
    output logic              repl_ready,
    input  logic [1:0]        repl_state,
    input  logic [ADDR_W-1:0] repl_addr,
    input  logic [DATA_W-1:0] repl_data,
    input  logic              repl_dirty,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hold,
    output logic              busy,
    input  logic              resp_valid,
    output logic              resp_ready,
    input  logic              resp_kind,
    input  logic              prb_valid,
    output logic              prb_ready,
    input  logic [1:0]        prb_kind,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              req_dirty,
    output logic              req_shared,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_kind,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              rsp_shared
);
    localparam int RQ_W = 1 + ADDR_W + DATA_W + 2;
    localparam int RS_W = 3 + ADDR_W + DATA_W + 2;

    logic              req_free, rsp_free, req_load, rsp_load;
    logic              rq_kind, rq_dirty, rq_shared;
    logic [ADDR_W-1:0] rq_addr, rs_addr;
    logic [DATA_W-1:0] rq_data, rs_data;
    logic [2:0]        rs_kind;
    logic              rs_dirty, rs_shared;
    logic [RQ_W-1:0]   rq_pkt, rq_out;
    logic [RS_W-1:0]   rs_pkt, rs_out;

    vwb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .repl_valid(repl_valid), .repl_state(repl_state), .repl_addr(repl_addr),
        .repl_data(repl_data), .repl_dirty(repl_dirty), .repl_ready(repl_ready),
        .lk_addr(lk_addr), .lk_hold(lk_hold), .busy(busy),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_ready(resp_ready),
        .prb_valid(prb_valid), .prb_kind(prb_kind), .prb_ready(prb_ready),
        .req_free(req_free), .rsp_free(rsp_free),
        .req_load(req_load), .rq_kind(rq_kind), .rq_addr(rq_addr),
        .rq_data(rq_data), .rq_dirty(rq_dirty), .rq_shared(rq_shared),
        .rsp_load(rsp_load), .rs_kind(rs_kind), .rs_addr(rs_addr),
        .rs_data(rs_data), .rs_dirty(rs_dirty), .rs_shared(rs_shared)
    );

    assign rq_pkt = {rq_kind, rq_addr, rq_data, rq_dirty, rq_shared};
    assign rs_pkt = {rs_kind, rs_addr, rs_data, rs_dirty, rs_shared};

    vwb_slot #(.W(RQ_W), .LAT(ISSUE_LAT)) u_req_slot (
        .clk(clk), .rst(rst), .load(req_load), .load_data(rq_pkt),
        .free(req_free), .out_valid(req_valid), .out_ready(req_ready),
        .out_data(rq_out)
    );

    vwb_slot #(.W(RS_W), .LAT(ISSUE_LAT)) u_rsp_slot (
        .clk(clk), .rst(rst), .load(rsp_load), .load_data(rs_pkt),
        .free(rsp_free), .out_valid(rsp_valid), .out_ready(rsp_ready),
        .out_data(rs_out)
    );

    assign {req_kind, req_addr, req_data, req_dirty, req_shared} = rq_out;
    assign {rsp_kind, rsp_addr, rsp_data, rsp_dirty, rsp_shared} = rs_out;

    AST_HOLD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        lk_hold |-> !repl_ready) else $error("hold while free"); // R4

endmodule

// File: tb/victim_wb_buf_bench.sv
`timescale 1ns/100ps
module victim_wb_buf_bench;
    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          repl_valid = 0, repl_ready, repl_dirty = 0;
    logic [1:0]    repl_state = 0;
    logic [AW-1:0] repl_addr = 0, lk_addr = 0, req_addr, rsp_addr;
    logic [DW-1:0] repl_data = 0, req_data, rsp_data;
    logic          lk_hold, busy;
    logic          resp_valid = 0, resp_ready, resp_kind = 0;
    logic          prb_valid = 0, prb_ready;
    logic [1:0]    prb_kind = 0;
    logic          req_valid, req_ready = 1, req_kind, req_dirty, req_shared;
    logic          rsp_valid, rsp_ready = 1, rsp_dirty, rsp_shared;
    logic [2:0]    rsp_kind;

    victim_wb_buf #(.ADDR_W(AW), .DATA_W(DW), .ISSUE_LAT(LAT)) u_victim_wb_buf (
        .clk(clk), .rst(rst),
        .repl_valid(repl_valid), .repl_ready(repl_ready), .repl_state(repl_state),
        .repl_addr(repl_addr), .repl_data(repl_data), .repl_dirty(repl_dirty),
        .lk_addr(lk_addr), .lk_hold(lk_hold), .busy(busy),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_kind(resp_kind),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .req_dirty(req_dirty),
        .req_shared(req_shared),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .rsp_shared(rsp_shared)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // event codes: 0 end, 1 ack, 2 nack, 3 inv, 4 inv+data, 5 downgrade
    int seq [0:7][0:3] = '{'{1,0,0,0}, '{2,0,0,0}, '{5,1,0,0}, '{3,1,0,0},
                           '{4,1,0,0}, '{3,2,0,0}, '{4,5,1,0}, '{5,3,4,2}};

    task automatic wait_req(output int n);
        n = 1;
        while (!req_valid && n < 40) begin @(negedge clk); n++; end
    endtask

    task automatic expect_rsp(input string tag, input int kind, input int data,
                              input int dirty, input int shared, input bit lat);
        int n;
        n = 1;
        while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
        if (lat) chk({tag, " R11 latency"}, n, LAT + 1);
        chk({tag, " kind"}, int'(rsp_kind), kind);
        chk({tag, " data"}, int'(rsp_data), data);
        chk({tag, " dirty"}, int'(rsp_dirty), dirty);
        chk({tag, " shared"}, int'(rsp_shared), shared);
    endtask

    task automatic expect_none(input string tag);
        bit seen;
        seen = 0;
        repeat (LAT + 3) begin @(negedge clk); if (rsp_valid) seen = 1; end
        chk({tag, " no message"}, int'(seen), 0);
    endtask

    task automatic send_probe(input int k);
        int guard;
        prb_valid = 1; prb_kind = 2'(k);
        guard = 0;
        while (1) begin
            #0.5;
            if (prb_ready || guard > 40) break;
            @(negedge clk); guard++;
        end
        @(negedge clk);
        prb_valid = 0;
    endtask

    task automatic send_resp(input int k);
        int guard;
        resp_valid = 1; resp_kind = 1'(k);
        guard = 0;
        while (1) begin
            #0.5;
            if (resp_ready || guard > 40) break;
            @(negedge clk); guard++;
        end
        @(negedge clk);
        resp_valid = 0;
    endtask

    task automatic do_evict(input int ls, input int a, input int d, input int dy);
        int n;
        repl_valid = 1; repl_state = 2'(ls); repl_addr = AW'(a);
        repl_data = DW'(d); repl_dirty = 1'(dy);
        #0.5 chk("R4 repl_ready before", int'(repl_ready), 1);
        @(negedge clk);
        repl_valid = 0;
        chk("R4 busy", int'(busy), 1);
        chk("R4 repl_ready while busy", int'(repl_ready), 0);
        lk_addr = AW'(a);
        #0.5 chk("R4 lk_hold match", int'(lk_hold), 1);
        lk_addr = AW'(a) ^ 8'h01;
        #0.5 chk("R4 lk_hold other", int'(lk_hold), 0);
        wait_req(n);
        chk("R11 req latency", n, LAT + 1);
        if (ls < 2) begin
            chk("R2 req kind", int'(req_kind), 0);
            chk("R2 req data", int'(req_data), 0);
            chk("R2 req dirty", int'(req_dirty), 0);
            chk("R2 req shared", int'(req_shared), (ls == 0) ? 1 : 0);
            chk("R2 req addr", int'(req_addr), a);
        end else begin
            chk("R3 req kind", int'(req_kind), 1);
            chk("R3 req data", int'(req_data), d);
            chk("R3 req dirty", int'(req_dirty), dy);
            chk("R3 req shared", int'(req_shared), (ls == 2) ? 1 : 0);
            chk("R3 req addr", int'(req_addr), a);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 req_valid", int'(req_valid), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 repl_ready", int'(repl_ready), 1);

        // R13 stimulus while empty
        prb_valid = 1; resp_valid = 1;
        #0.5 chk("R13 prb_ready idle", int'(prb_ready), 0);
        chk("R13 resp_ready idle", int'(resp_ready), 0);
        @(negedge clk);
        prb_valid = 0; resp_valid = 0;
        expect_none("R13 idle");

        // sweep: every line state against every event sequence
        for (int ls = 0; ls < 4; ls++) begin
            for (int sc = 0; sc < 8; sc++) begin
                int d, dy, a;
                bit psh, canc;
                d  = (ls * 37 + sc * 11 + 5) & 8'hff;
                dy = (sc ^ ls) & 1;
                a  = (16 * ls + sc + 2) & 8'hff;
                psh = 0; canc = 0;
                do_evict(ls, a, d, dy);
                for (int st = 0; st < 4; st++) begin
                    int e;
                    e = seq[sc][st];
                    if (e == 0) break;
                    if (e == 1) begin
                        send_resp(0);
                        if (canc) expect_rsp("R9 stale", 1, 0, 0, 0, 1);
                        else      expect_rsp("R5 wb data", 0, d, dy, int'(psh), 1);
                        chk("R5 freed", int'(busy), 0);
                    end else if (e == 2) begin
                        send_resp(1);
                        expect_none("R6 nack");
                        chk("R6 freed", int'(busy), 0);
                    end else begin
                        send_probe(e == 3 ? 0 : (e == 4 ? 1 : 2));
                        if (canc) begin
                            if (e == 5) expect_rsp("R10 miss", 4, 0, 0, 0, 1);
                            else        expect_rsp("R9 inv after cancel", 3, 0, 0, 0, 1);
                        end else if (e == 5) begin
                            expect_rsp("R7 downgrade", 2, d, dy, 0, 1);
                            psh = 1;
                        end else if (e == 4) begin
                            expect_rsp("R8 inv data", 2, d, dy, 0, 1);
                            canc = 1;
                        end else begin
                            expect_rsp("R8 inv", 3, 0, 0, 0, 1);
                            canc = 1;
                        end
                        chk("R7 still busy after probe", int'(busy), 1);
                    end
                end
                @(negedge clk);
            end
        end

        // R12 probe and response together: downgrade wins, ack follows with shared set
        do_evict(3, 8'h5a, 8'hc3, 1);
        prb_valid = 1; prb_kind = 2'd2; resp_valid = 1; resp_kind = 0;
        #0.5 chk("R12 prb_ready", int'(prb_ready), 1);
        chk("R12 resp_ready", int'(resp_ready), 0);
        @(negedge clk);
        prb_valid = 0;
        chk("R12 response still pending", int'(busy), 1);
        expect_rsp("R12 probe first", 2, 8'hc3, 1, 0, 1);
        begin
            int guard;
            guard = 0;
            while (1) begin
                #0.5;
                if (resp_ready || guard > 40) break;
                @(negedge clk); guard++;
            end
            @(negedge clk);
            resp_valid = 0;
        end
        expect_rsp("R12 ack after probe", 0, 8'hc3, 1, 1, 1);

        // R11 backpressure on the response channel
        @(negedge clk);
        do_evict(2, 8'h33, 8'h7e, 0);
        rsp_ready = 0;
        send_resp(0);
        expect_rsp("R11 bp first", 0, 8'h7e, 0, 0, 1);
        repeat (3) @(negedge clk);
        chk("R11 bp valid held", int'(rsp_valid), 1);
        chk("R11 bp data held", int'(rsp_data), 8'h7e);
        rsp_ready = 1;
        @(negedge clk);
        chk("R11 bp drained", int'(rsp_valid), 0);

        done = 1;
        report();
    end
endmodule